// File: doc/BRIEF.md
# Strided tile transfer engine

This block turns one tile move command into a stream of single-element memory requests. A command names the direction, an operand class and an element width, and gives a base address and a byte distance between rows. Load commands write into a flat vector register group. Store commands read from it. Element k of the transfer sits at a row and column position in the tile. Its memory address advances by the element size along a row and then jumps by the row distance. Its position in the register group is simply k.

The number of elements moved is the smaller of the vector capacity and the tile size for the chosen class. The vector capacity is the vector length divided by the element width, times the register group multiplier. When that limit falls inside a row, the transfer stops there. One request is offered per cycle on a valid/ready port. Load data comes back in the same cycle as the accepted request and is written into the register group one cycle later. A busy flag covers the whole transfer, and a one-cycle done pulse closes it.

Top module: `tile_xfer_engine`

## Requirements
- R1: Width code `cmd_ew` 0/1/2/3 means 8/16/32/64-bit elements (size 1<<code bytes, given on `mem_req_size`). A command is rejected when `cfg_vsew` differs from `cmd_ew` or when `cmd_cls` is 3. A rejected command raises `cmd_reject` for the one cycle after acceptance and starts no transfer.
- R2: A command is taken only while `busy` is low. A command presented while busy is ignored: it causes no requests after the current transfer ends.
- R3: The element count is min((VLEN/8 >> cmd_ew) << cfg_lmul_log2, size). The size is tile_m*tile_k for class 0 (A), tile_k*tile_n for class 1 (B) and tile_m*tile_n for class 2 (C).
- R4: The row length is tile_k for class A and tile_n for classes B and C. Element k lies in row k / row_length and column k % row_length.
- R5: The address of element k is base + row*stride + column*(1<<cmd_ew), modulo 2^ADDR_W.
- R6: Element k uses register group index k, on `vreg_idx` while it is requested.
- R7: At most one element is transferred per cycle. While `mem_req_valid` is high and `mem_req_ready` is low, the request and all its fields hold.
- R8: For a load, `mem_req_we` is 0. The cycle after each accepted request, `vreg_we` pulses with that element's index and the low element-size bytes of `mem_rdata`, with the upper bytes zero.
- R9: For a store, `mem_req_we` is 1, and `mem_req_wdata` is the low element-size bytes of `vreg_rdata`, upper bytes zero. Stores never assert `vreg_we`.
- R10: `done` pulses for one cycle, the cycle after the last accepted request, and `busy` is low in that cycle. A command with a count of zero gives `done` one cycle after acceptance and makes no requests.
- R11: When the count limit ends inside a row, the remaining columns of that row are never requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_cls | input | 2 | Operand class: 0 A, 1 B, 2 C |
| cmd_ew | input | 2 | Element width code |
| cmd_base | input | ADDR_W | Base byte address |
| cmd_stride | input | ADDR_W | Byte distance between rows |
| cfg_vsew | input | 2 | Vector element width code |
| cfg_lmul_log2 | input | 2 | log2 of register group multiplier |
| tile_m | input | TDIM_W | Tile M dimension |
| tile_k | input | TDIM_W | Tile K dimension |
| tile_n | input | TDIM_W | Tile N dimension |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| cmd_reject | output | 1 | Rejected command pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Element byte address |
| mem_req_size | output | 2 | Element width code |
| mem_req_wdata | output | DATA_W | Store data, zero-extended |
| mem_rdata | input | DATA_W | Load data for current request |
| vreg_idx | output | CNT_W | Register group index of current element |
| vreg_rdata | input | DATA_W | Register group data at vreg_idx |
| vreg_we | output | 1 | Register group write strobe |
| vreg_widx | output | CNT_W | Register group write index |
| vreg_wdata | output | DATA_W | Register group write data |

## Verification
The sweep covers every class, width and direction under several group multipliers, and several tile shapes with rows of different lengths. This separates a wrong row length or a mixed-up class product, which shifts addresses at row ends, from a wrong element step, which shifts them inside a row. Small multipliers with wide elements stop a transfer partway through a row, which exposes a count that rounds up to whole rows. Zero-sized tiles, mismatched widths, the reserved class and a command poked mid-transfer test the paths where nothing must happen. Random ready stalls show that address, index and data stay tied to the same element.

// File: rtl/tx_pkg.sv
// Shared encodings for the strided tile transfer engine.
// Assumes element data fits a 64-bit lane.
package tx_pkg;
    typedef enum logic [1:0] {
        CLS_A   = 2'd0,
        CLS_B   = 2'd1,
        CLS_C   = 2'd2,
        CLS_RSV = 2'd3
    } tile_cls_e;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } elem_w_e;

    // Element size in bytes for a width code.
    function automatic logic [4:0] ew_bytes(input logic [1:0] ew);
        return 5'd1 << ew;
    endfunction
endpackage

// File: rtl/tx_limit.sv
// Derives row length and element count for a command.
// Purely combinational; inputs are the live command and tile settings.
// Assumes VLEN is a multiple of 64.
module tx_limit #(
    parameter int VLEN   = 512,
    parameter int TDIM_W = 8,
    parameter int CNT_W  = $clog2(VLEN) + 1
) (
    input  logic [1:0]        cls,
    input  logic [1:0]        ew,
    input  logic [1:0]        lmul_log2,
    input  logic [TDIM_W-1:0] tm,
    input  logic [TDIM_W-1:0] tk,
    input  logic [TDIM_W-1:0] tn,
    output logic [TDIM_W-1:0] row_len,
    output logic [CNT_W-1:0]  total
);
    import tx_pkg::*;

    localparam int PW = 2 * TDIM_W;
    localparam int MW = (PW > CNT_W) ? PW : CNT_W;

    logic [MW-1:0] vlmax;
    logic [MW-1:0] msize;
    logic [PW-1:0] prod;

    // Pick the tile product and row length by class, then cap by capacity.
    always_comb begin
        vlmax = MW'(VLEN / 8);
        vlmax = (vlmax >> ew) << lmul_log2;
        unique case (tile_cls_e'(cls))
            CLS_A:   begin prod = PW'(tm) * PW'(tk); row_len = tk; end
            CLS_B:   begin prod = PW'(tk) * PW'(tn); row_len = tn; end
            default: begin prod = PW'(tm) * PW'(tn); row_len = tn; end
        endcase
        msize = MW'(prod);
        total = CNT_W'((vlmax < msize) ? vlmax : msize);
    end
endmodule

// File: rtl/tx_walker.sv
// Walks a tile row by row, producing the element address and flat index.
// Addresses step by element size in a row and by the stride between rows.
// Assumes row_len is nonzero whenever total is nonzero.
module tx_walker #(
    parameter int ADDR_W = 32,
    parameter int TDIM_W = 8,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [1:0]        ew,
    input  logic [TDIM_W-1:0] row_len,
    input  logic [CNT_W-1:0]  total,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  idx,
    output logic              last
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  total_q;
    logic [TDIM_W-1:0] col_q;
    logic [TDIM_W-1:0] row_len_q;
    logic [ADDR_W-1:0] row_addr_q;
    logic [ADDR_W-1:0] elem_addr_q;
    logic [ADDR_W-1:0] stride_q;
    logic [1:0]        ew_q;
    logic              row_end;
    logic [ADDR_W-1:0] step;

    // Decode the end of a row and the in-row address step.
    always_comb begin
        row_end = (col_q == row_len_q - 1'b1);
        step    = ADDR_W'(1) << ew_q;
    end

    // Latch the command, then advance column, row and address per element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            total_q     <= '0;
            col_q       <= '0;
            row_len_q   <= '0;
            row_addr_q  <= '0;
            elem_addr_q <= '0;
            stride_q    <= '0;
            ew_q        <= '0;
        end else if (start) begin
            cnt_q       <= '0;
            total_q     <= total;
            col_q       <= '0;
            row_len_q   <= row_len;
            row_addr_q  <= base;
            elem_addr_q <= base;
            stride_q    <= stride;
            ew_q        <= ew;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
            if (row_end) begin
                col_q       <= '0;
                row_addr_q  <= row_addr_q + stride_q;
                elem_addr_q <= row_addr_q + stride_q;
            end else begin
                col_q       <= col_q + 1'b1;
                elem_addr_q <= elem_addr_q + step;
            end
        end
    end

    assign addr = elem_addr_q;
    assign idx  = cnt_q;
    assign last = (CNT_W'(cnt_q + 1'b1) == total_q);

    // The counter never runs past the latched element count.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= total_q);

    // The column stays inside the latched row length.
    a_r4_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (row_len_q == '0) || (col_q < row_len_q));

    // A row wrap moves the element address to the next row start.
    a_r5_row_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !start && row_end) |=> (elem_addr_q == row_addr_q));
endmodule

// File: rtl/tx_lanes.sv
// Byte-lane masking for store data and the registered write into the
// vector register group on loads. Assumes DATA_W is 64.
module tx_lanes #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ew,
    input  logic              load_hs,
    input  logic [CNT_W-1:0]  hs_idx,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] vreg_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              vreg_we,
    output logic [CNT_W-1:0]  vreg_widx,
    output logic [DATA_W-1:0] vreg_wdata
);
    import tx_pkg::*;

    localparam int NB = DATA_W / 8;

    logic [DATA_W-1:0] keep;
    logic [4:0]        esz;

    assign esz = ew_bytes(ew);

    // One byte-enable per lane: lanes below the element size pass.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign keep[8*b +: 8] = {8{5'(b) < esz}};
    end

    assign mem_wdata = vreg_rdata & keep;

    // Register the masked load data with its index for the register group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vreg_we    <= 1'b0;
            vreg_widx  <= '0;
            vreg_wdata <= '0;
        end else begin
            vreg_we <= load_hs;
            if (load_hs) begin
                vreg_widx  <= hs_idx;
                vreg_wdata <= mem_rdata & keep;
            end
        end
    end

    // Every register group write follows an accepted load request.
    a_r8_we_follows: assert property (@(posedge clk) disable iff (!rst_n)
        vreg_we |-> $past(load_hs));

    // A write carries the index that was requested one cycle earlier.
    a_r8_widx_match: assert property (@(posedge clk) disable iff (!rst_n)
        load_hs |=> (vreg_widx == $past(hs_idx)));
endmodule

// File: rtl/tile_xfer_engine.sv
// Top of the strided tile transfer engine. Accepts one command while idle,
// checks widths and class, then issues one element request per cycle on a
// valid/ready port until the capped count is reached.
// Assumes mem_rdata is valid in the cycle a load request is accepted and
// vreg_rdata is valid combinationally for vreg_idx.
module tile_xfer_engine #(
    parameter int ADDR_W = 32,
    parameter int VLEN   = 512,
    parameter int TDIM_W = 8,
    parameter int DATA_W = 64,
    localparam int CNT_W = $clog2(VLEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic [1:0]        cmd_cls,
    input  logic [1:0]        cmd_ew,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [1:0]        cfg_vsew,
    input  logic [1:0]        cfg_lmul_log2,
    input  logic [TDIM_W-1:0] tile_m,
    input  logic [TDIM_W-1:0] tile_k,
    input  logic [TDIM_W-1:0] tile_n,
    output logic              busy,
    output logic              done,
    output logic              cmd_reject,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [1:0]        mem_req_size,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  vreg_idx,
    input  logic [DATA_W-1:0] vreg_rdata,
    output logic              vreg_we,
    output logic [CNT_W-1:0]  vreg_widx,
    output logic [DATA_W-1:0] vreg_wdata
);
    import tx_pkg::*;

    logic [TDIM_W-1:0] lim_row_len;
    logic [CNT_W-1:0]  lim_total;
    logic              accept;
    logic              bad_cmd;
    logic              accept_ok;
    logic              hs;
    logic              last;
    logic              store_q;
    logic [1:0]        ew_q;

    tx_limit #(
        .VLEN   (VLEN),
        .TDIM_W (TDIM_W),
        .CNT_W  (CNT_W)
    ) u_limit (
        .cls       (cmd_cls),
        .ew        (cmd_ew),
        .lmul_log2 (cfg_lmul_log2),
        .tm        (tile_m),
        .tk        (tile_k),
        .tn        (tile_n),
        .row_len   (lim_row_len),
        .total     (lim_total)
    );

    // Command acceptance and validity decode.
    always_comb begin
        accept    = cmd_valid && !busy;
        bad_cmd   = (cfg_vsew != cmd_ew) || (tile_cls_e'(cmd_cls) == CLS_RSV);
        accept_ok = accept && !bad_cmd;
        hs        = busy && mem_req_ready;
    end

    tx_walker #(
        .ADDR_W (ADDR_W),
        .TDIM_W (TDIM_W),
        .CNT_W  (CNT_W)
    ) u_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept_ok),
        .advance (hs),
        .base    (cmd_base),
        .stride  (cmd_stride),
        .ew      (cmd_ew),
        .row_len (lim_row_len),
        .total   (lim_total),
        .addr    (mem_req_addr),
        .idx     (vreg_idx),
        .last    (last)
    );

    tx_lanes #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .ew         (ew_q),
        .load_hs    (hs && !store_q),
        .hs_idx     (vreg_idx),
        .mem_rdata  (mem_rdata),
        .vreg_rdata (vreg_rdata),
        .mem_wdata  (mem_req_wdata),
        .vreg_we    (vreg_we),
        .vreg_widx  (vreg_widx),
        .vreg_wdata (vreg_wdata)
    );

    // Sequence control: busy window, done and reject pulses, command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            cmd_reject <= 1'b0;
            store_q    <= 1'b0;
            ew_q       <= '0;
        end else begin
            done       <= (accept_ok && (lim_total == '0)) || (hs && last);
            cmd_reject <= accept && bad_cmd;
            if (accept_ok) begin
                store_q <= cmd_store;
                ew_q    <= cmd_ew;
            end
            if (accept_ok && (lim_total != '0)) begin
                busy <= 1'b1;
            end else if (hs && last) begin
                busy <= 1'b0;
            end
        end
    end

    assign mem_req_valid = busy;
    assign mem_req_we    = store_q;
    assign mem_req_size  = ew_q;

    // A stalled request holds its address and index.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(vreg_idx)));

    // The done pulse never overlaps an outstanding request.
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req_valid);

    // A rejected command leaves the engine idle.
    a_r1_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> (!busy && !done));

    // A command seen while busy does not restart the walk.
    a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && !mem_req_ready) |=> $stable(vreg_idx));
endmodule

// File: tb/sim_tile_xfer_engine.sv
module sim_tile_xfer_engine;
    localparam int ADDR_W = 32;
    localparam int VLEN   = 128;
    localparam int TDIM_W = 4;
    localparam int DATA_W = 64;
    localparam int CNT_W  = $clog2(VLEN) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_store = 1'b0;
    logic [1:0]        cmd_cls = '0;
    logic [1:0]        cmd_ew = '0;
    logic [ADDR_W-1:0] cmd_base = '0;
    logic [ADDR_W-1:0] cmd_stride = '0;
    logic [1:0]        cfg_vsew = '0;
    logic [1:0]        cfg_lmul_log2 = '0;
    logic [TDIM_W-1:0] tile_m = '0;
    logic [TDIM_W-1:0] tile_k = '0;
    logic [TDIM_W-1:0] tile_n = '0;
    logic              busy, done, cmd_reject;
    logic              mem_req_valid, mem_req_we;
    logic              mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [1:0]        mem_req_size;
    logic [DATA_W-1:0] mem_req_wdata, mem_rdata;
    logic [CNT_W-1:0]  vreg_idx, vreg_widx;
    logic [DATA_W-1:0] vreg_rdata, vreg_wdata;
    logic              vreg_we;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;
    bit  full_rdy = 0;
    logic [15:0] lf = 16'hACE1;

    always #4 clk = ~clk;

    function automatic logic [DATA_W-1:0] memword(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] w;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] x;
            x = a + 32'(i);
            w[8*i +: 8] = x[7:0] ^ x[15:8] ^ x[23:16] ^ x[31:24] ^ {x[3:0], x[7:4]} ^ 8'h5A;
        end
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] vpat(input logic [CNT_W-1:0] i);
        return 64'h0123_4567_89AB_CDEF + 64'(i) * 64'h0101_0101_0101_0101;
    endfunction

    function automatic logic [DATA_W-1:0] lmask(input logic [1:0] ew);
        return (ew == 2'd3) ? '1 : ((64'd1 << (8 << ew)) - 64'd1);
    endfunction

    assign mem_rdata  = memword(mem_req_addr);
    assign vreg_rdata = vpat(vreg_idx);

    tile_xfer_engine #(
        .ADDR_W (ADDR_W), .VLEN (VLEN), .TDIM_W (TDIM_W), .DATA_W (DATA_W)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_store (cmd_store),
        .cmd_cls (cmd_cls), .cmd_ew (cmd_ew), .cmd_base (cmd_base),
        .cmd_stride (cmd_stride), .cfg_vsew (cfg_vsew), .cfg_lmul_log2 (cfg_lmul_log2),
        .tile_m (tile_m), .tile_k (tile_k), .tile_n (tile_n),
        .busy (busy), .done (done), .cmd_reject (cmd_reject),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_we (mem_req_we), .mem_req_addr (mem_req_addr),
        .mem_req_size (mem_req_size), .mem_req_wdata (mem_req_wdata),
        .mem_rdata (mem_rdata), .vreg_idx (vreg_idx), .vreg_rdata (vreg_rdata),
        .vreg_we (vreg_we), .vreg_widx (vreg_widx), .vreg_wdata (vreg_wdata)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Issue one command from just after a negedge and check every element.
    task automatic run_cmd(input bit st, input logic [1:0] cls, input logic [1:0] ew,
                           input logic [1:0] vs, input logic [1:0] lm,
                           input int tm, input int tk, input int tn,
                           input logic [31:0] base, input logic [31:0] stride, input bit poke);
        int tot, rl, k, vlmax, msz;
        bit pend, bad, stalled, rdy;
        logic [CNT_W-1:0] pidx;
        logic [63:0] pdat;
        logic [31:0] ea;
        bad   = (vs != ew) || (cls == 2'd3);
        vlmax = ((VLEN / 8) >> ew) << lm;
        msz   = (cls == 2'd0) ? tm * tk : (cls == 2'd1) ? tk * tn : tm * tn;
        tot   = (vlmax < msz) ? vlmax : msz;
        rl    = (cls == 2'd0) ? tk : tn;
        cmd_store = st; cmd_cls = cls; cmd_ew = ew; cfg_vsew = vs; cfg_lmul_log2 = lm;
        tile_m = TDIM_W'(tm); tile_k = TDIM_W'(tk); tile_n = TDIM_W'(tn);
        cmd_base = base; cmd_stride = stride; cmd_valid = 1'b1; mem_req_ready = 1'b0;
        @(posedge clk); #1 cmd_valid = 1'b0;
        if (bad) begin
            @(negedge clk);
            check(cmd_reject && !busy && !mem_req_valid && !done, "R1 reject", {cmd_reject, busy, mem_req_valid}, 64'h4);
            @(negedge clk);
            check(!cmd_reject && !busy && !mem_req_valid, "R1 no start", {cmd_reject, busy, mem_req_valid}, 64'h0);
            return;
        end
        k = 0; pend = 0; stalled = 0;
        for (int cyc = 0; cyc < 600; cyc++) begin
            @(negedge clk);
            if (poke && cyc == 1) begin cmd_valid = 1'b1; cmd_base = base ^ 32'h0000_5A00; end
            if (poke && cyc == 2) cmd_valid = 1'b0;
            if (pend) begin
                check(vreg_we && vreg_widx == pidx, "R8 write index", {vreg_we, vreg_widx}, {1'b1, pidx});
                check(vreg_wdata == pdat, "R8 load data", vreg_wdata, pdat);
            end else begin
                check(!vreg_we, "R9 no stray write", vreg_we, 0);
            end
            pend = 0;
            if (stalled) check(mem_req_valid, "R7 held", mem_req_valid, 1);
            if (done) break;
            if (full_rdy) rdy = 1;
            else begin
                lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                rdy = lf[0] | lf[1];
            end
            mem_req_ready = rdy;
            #1;
            stalled = mem_req_valid && !rdy;
            if (mem_req_valid) begin
                ea = base + 32'(k / rl) * stride + 32'((k % rl) << ew);
                check(mem_req_addr == ea, "R5 address", mem_req_addr, ea);
                check(vreg_idx == CNT_W'(k), "R6 index", vreg_idx, k);
                check(mem_req_we == st && mem_req_size == ew, "R1 size/R9 we", {mem_req_we, mem_req_size}, {st, ew});
                if (st) check(mem_req_wdata == (vpat(CNT_W'(k)) & lmask(ew)), "R9 store data",
                              mem_req_wdata, vpat(CNT_W'(k)) & lmask(ew));
                if (rdy) begin
                    if (!st) begin pend = 1; pidx = CNT_W'(k); pdat = memword(ea) & lmask(ew); end
                    k++;
                end
            end
        end
        cmd_valid = 1'b0; mem_req_ready = 1'b0;
        check(done && !busy, "R10 done/busy", {done, busy}, 64'h2);
        if (tot < msz && (tot % rl) != 0)
            check(k == tot, "R11 mid-row stop", k, tot);
        else
            check(k == tot, "R3 count", k, tot);
        @(negedge clk);
        check(!done && !mem_req_valid, "R10 single pulse", {done, mem_req_valid}, 0);
        if (poke) begin
            @(negedge clk);
            check(!busy && !mem_req_valid, "R2 ignored while busy", {busy, mem_req_valid}, 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int tms[4] = '{3, 4, 2, 0};
        int tks[4] = '{5, 4, 3, 3};
        int tns[4] = '{2, 4, 7, 3};
        logic [31:0] strides[4] = '{32'd64, 32'd200, 32'd12, 32'hFFFF_FF00};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !cmd_reject && !mem_req_valid && !vreg_we, "R10 reset state",
              {busy, done, cmd_reject, mem_req_valid, vreg_we}, 0);
        for (int t = 0; t < 4; t++)
            for (int c = 0; c < 3; c++)
                for (int e = 0; e < 4; e++)
                    for (int l = 0; l < 4; l++)
                        for (int s = 0; s < 2; s++) begin
                            full_rdy = (l == 2);
                            run_cmd(s[0], 2'(c), 2'(e), 2'(e), 2'(l), tms[t], tks[t], tns[t],
                                    32'h0000_1000 + 32'(t * 16), strides[t], 0);
                        end
        // R1: width mismatch and reserved class.
        full_rdy = 0;
        run_cmd(0, 2'd0, 2'd1, 2'd2, 2'd0, 3, 3, 3, 32'h100, 32'd40, 0);
        run_cmd(1, 2'd3, 2'd2, 2'd2, 2'd0, 3, 3, 3, 32'h100, 32'd40, 0);
        // R2: command poked mid-transfer is ignored.
        run_cmd(0, 2'd2, 2'd0, 2'd0, 2'd3, 4, 4, 5, 32'h2000, 32'd32, 1);
        run_cmd(1, 2'd1, 2'd1, 2'd1, 2'd3, 4, 3, 4, 32'h3000, 32'd20, 1);
        summary();
    end
endmodule